// File: doc/BRIEF.md
# Daisy-Chained Interrupt Request Controller

This block is one interrupt source on a priority daisy chain. It watches an external interrupt line. After two synchronizing flops, a falling edge on that line latches a pending request, provided interrupts are enabled. The block pulls its active-low request output down only while the upstream priority input grants it the chain, which is also active low. When it is not requesting, it hands the grant on to the downstream neighbour through its own priority output.

The CPU steers the block with a 5-bit command code. The code is qualified by a one-cycle strobe that marks each cycle boundary. Code 0x10 freezes both chain outputs so that the winner cannot change during acknowledge. Codes 0x0F and 0x13, when the block holds the chain, return the lower and then the upper byte of a 16-bit vector on a byte-wide bus with its own drive-enable. The upper-byte fetch also clears the pending request.

Top module: `irq_chain_ctl`

## Requirements
- R1: A high-to-low transition of `ext_irq_i`, driven just after a clock edge, shows on `irq_req_n_o` after the third rising edge, when `pri_in_n_i` is low. A low-to-high transition never sets a request.
- R2: `irq_req_n_o` is low only when `pri_in_n_i` is low and a request is pending. Otherwise it is high.
- R3: `pri_out_n_o` is low only when `pri_in_n_i` is low and no request is pending. Otherwise it is high.
- R4: A strobed code 0x0F, seen while `irq_req_n_o` is low, makes the next cycle show `vbus_oe_o`=1 and `vbus_o`=`vector_i[7:0]`.
- R5: A strobed code 0x13, seen while `irq_req_n_o` is low, makes the next cycle show `vbus_oe_o`=1 and `vbus_o`=`vector_i[15:8]`. It also clears the pending request, so `irq_req_n_o` is high from that cycle on.
- R6: A strobed code 0x10 freezes `irq_req_n_o` and `pri_out_n_o` at their values in the strobe cycle. The freeze lasts until a strobe carries any other code.
- R7: While `irq_en_i` is low, falling edges on `ext_irq_i` are ignored and no request becomes pending.
- R8: `vbus_oe_o` is high only in the cycle after an accepted vector command, and `vbus_o` is zero whenever `vbus_oe_o` is low. A code without the strobe, or without the grant, gives no drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_irq_i | input | 1 | External interrupt line, falling edge requests |
| pri_in_n_i | input | 1 | Priority grant from upstream, active low |
| cmd_i | input | 5 | CPU command code |
| cmd_stb_i | input | 1 | Marks the cycle in which `cmd_i` is valid |
| irq_en_i | input | 1 | Interrupt enable |
| vector_i | input | 16 | Interrupt vector value |
| irq_req_n_o | output | 1 | Interrupt request to CPU, active low |
| pri_out_n_o | output | 1 | Priority grant to downstream, active low |
| vbus_o | output | 8 | Vector byte returned on the data bus |
| vbus_oe_o | output | 1 | Data bus drive-enable for `vbus_o` |

## Verification
Several properties are checked on every cycle:
- the request and priority outputs are never both low;
- outside a freeze, the request is never asserted without the upstream grant;
- both chain outputs stay still for as long as the freeze lasts;
- the bus drive only follows a strobed vector code;
- a request never becomes pending while interrupts are disabled.

Some behaviours can only be shown by the bench's scenarios:
- the exact latency of edge detection;
- that rising edges are ignored;
- which vector byte each code returns;
- the clearing by the upper-byte fetch;
- the release of the freeze by a later code.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;
  localparam int CMD_W = 5;

  typedef enum logic [CMD_W-1:0] {
    CMD_VEC_LO  = 5'h0F,
    CMD_INHIBIT = 5'h10,
    CMD_VEC_HI  = 5'h13
  } irq_cmd_e;
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  input  logic en_i,
  output logic fall_o
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;
  logic              prev_d;

  // Synchronizer chain; stage 0 samples the pin.
  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_comb sync_d[i] = async_i;
      end else begin : g_next
        always_comb sync_d[i] = sync_q[i-1];
      end
    end
  endgenerate

  always_comb prev_d = sync_q[LAST];

  // Idle level of the line is high, so reset to ones.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  always_comb fall_o = en_i & prev_q & ~sync_q[LAST];
endmodule

// File: rtl/irq_pend.sv
module irq_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  logic pend_q;
  logic pend_d;

  // A fresh edge outranks a clear in the same cycle.
  always_comb begin
    pend_d = pend_q;
    if (clr_i) pend_d = 1'b0;
    if (set_i) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  always_comb pend_o = pend_q;
endmodule

// File: rtl/irq_chain_gate.sv
module irq_chain_gate
  import irq_chain_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pend_i,
  input  logic             pri_in_n_i,
  input  logic             cmd_stb_i,
  input  logic [CMD_W-1:0] cmd_i,
  output logic             req_n_o,
  output logic             pri_out_n_o,
  output logic             inhib_o
);
  logic live_req_n;
  logic live_pri_n;
  logic inhib_q;
  logic inhib_d;
  logic held_req_n_q;
  logic held_pri_n_q;
  logic hold_en;

  always_comb begin
    live_req_n = ~(pend_i & ~pri_in_n_i);
    live_pri_n = pri_in_n_i | pend_i;
  end

  // Freeze state changes only at strobed cycle boundaries.
  always_comb begin
    inhib_d = inhib_q;
    if (cmd_stb_i) inhib_d = (cmd_i == CMD_INHIBIT);
  end

  always_comb hold_en = ~inhib_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inhib_q      <= 1'b0;
      held_req_n_q <= 1'b1;
      held_pri_n_q <= 1'b1;
    end else begin
      inhib_q <= inhib_d;
      if (hold_en) begin
        held_req_n_q <= live_req_n;
        held_pri_n_q <= live_pri_n;
      end
    end
  end

  always_comb begin
    req_n_o     = inhib_q ? held_req_n_q : live_req_n;
    pri_out_n_o = inhib_q ? held_pri_n_q : live_pri_n;
    inhib_o     = inhib_q;
  end
endmodule

// File: rtl/irq_vec_out.sv
module irq_vec_out
  import irq_chain_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_stb_i,
  input  logic [CMD_W-1:0]    cmd_i,
  input  logic                granted_i,
  input  logic [2*BYTE_W-1:0] vector_i,
  output logic [BYTE_W-1:0]   data_o,
  output logic                oe_o,
  output logic                clr_o
);
  localparam int VEC_W = 2 * BYTE_W;

  logic              hit_lo;
  logic              hit_hi;
  logic              oe_q;
  logic              oe_d;
  logic [BYTE_W-1:0] data_q;
  logic [BYTE_W-1:0] data_d;

  always_comb begin
    hit_lo = cmd_stb_i & granted_i & (cmd_i == CMD_VEC_LO);
    hit_hi = cmd_stb_i & granted_i & (cmd_i == CMD_VEC_HI);
    oe_d   = hit_lo | hit_hi;
    data_d = '0;
    if (hit_lo) data_d = vector_i[BYTE_W-1:0];
    if (hit_hi) data_d = vector_i[VEC_W-1 -: BYTE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q   <= 1'b0;
      data_q <= '0;
    end else begin
      oe_q   <= oe_d;
      data_q <= data_d;
    end
  end

  always_comb begin
    data_o = data_q;
    oe_o   = oe_q;
    clr_o  = hit_hi;
  end
endmodule

// File: rtl/irq_chain_ctl.sv
module irq_chain_ctl
  import irq_chain_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ext_irq_i,
  input  logic                pri_in_n_i,
  input  logic [CMD_W-1:0]    cmd_i,
  input  logic                cmd_stb_i,
  input  logic                irq_en_i,
  input  logic [2*BYTE_W-1:0] vector_i,
  output logic                irq_req_n_o,
  output logic                pri_out_n_o,
  output logic [BYTE_W-1:0]   vbus_o,
  output logic                vbus_oe_o
);
  logic fall_w;
  logic pend_w;
  logic clr_w;
  logic inhib_w;
  logic granted_w;

  irq_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (ext_irq_i),
    .en_i    (irq_en_i),
    .fall_o  (fall_w)
  );

  irq_pend u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (fall_w),
    .clr_i  (clr_w),
    .pend_o (pend_w)
  );

  irq_chain_gate u_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .pend_i      (pend_w),
    .pri_in_n_i  (pri_in_n_i),
    .cmd_stb_i   (cmd_stb_i),
    .cmd_i       (cmd_i),
    .req_n_o     (irq_req_n_o),
    .pri_out_n_o (pri_out_n_o),
    .inhib_o     (inhib_w)
  );

  always_comb granted_w = ~irq_req_n_o;

  irq_vec_out #(.BYTE_W(BYTE_W)) u_vec (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_stb_i (cmd_stb_i),
    .cmd_i     (cmd_i),
    .granted_i (granted_w),
    .vector_i  (vector_i),
    .data_o    (vbus_o),
    .oe_o      (vbus_oe_o),
    .clr_o     (clr_w)
  );
endmodule

// File: rtl/irq_chain_ctl_chk.sv
module irq_chain_ctl_chk
  import irq_chain_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pri_in_n_i,
  input logic [CMD_W-1:0]  cmd_i,
  input logic              cmd_stb_i,
  input logic              irq_en_i,
  input logic              irq_req_n_o,
  input logic              pri_out_n_o,
  input logic [BYTE_W-1:0] vbus_o,
  input logic              vbus_oe_o,
  input logic              inhib_w,
  input logic              pend_w
);
  // R2
  req_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!inhib_w && !irq_req_n_o) |-> !pri_in_n_i);

  // R3
  req_blocks_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req_n_o |-> pri_out_n_o);

  // R6
  frozen_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inhib_w && $past(inhib_w)) |-> ($stable(irq_req_n_o) && $stable(pri_out_n_o)));

  // R8
  drive_after_vec_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vbus_oe_o |-> ($past(cmd_stb_i) &&
                   ($past(cmd_i) == CMD_VEC_LO || $past(cmd_i) == CMD_VEC_HI)));

  // R8
  idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vbus_oe_o |-> (vbus_o == '0));

  // R7
  no_set_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_w) |-> $past(irq_en_i));
endmodule

bind irq_chain_ctl irq_chain_ctl_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pri_in_n_i  (pri_in_n_i),
  .cmd_i       (cmd_i),
  .cmd_stb_i   (cmd_stb_i),
  .irq_en_i    (irq_en_i),
  .irq_req_n_o (irq_req_n_o),
  .pri_out_n_o (pri_out_n_o),
  .vbus_o      (vbus_o),
  .vbus_oe_o   (vbus_oe_o),
  .inhib_w     (inhib_w),
  .pend_w      (pend_w)
);

// File: tb/test_irq_chain_ctl.sv
module test_irq_chain_ctl;
  logic        clk;
  logic        rst_n;
  logic        ext_irq_i;
  logic        pri_in_n_i;
  logic [4:0]  cmd_i;
  logic        cmd_stb_i;
  logic        irq_en_i;
  logic [15:0] vector_i;
  logic        irq_req_n_o;
  logic        pri_out_n_o;
  logic [7:0]  vbus_o;
  logic        vbus_oe_o;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done   = 0;
  bit model_pend = 0;

  typedef struct {
    int         due;
    logic       oe;
    logic [7:0] d;
    string      req;
  } sb_item_t;
  sb_item_t sbq[$];

  irq_chain_ctl i_irq_chain_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .ext_irq_i   (ext_irq_i),
    .pri_in_n_i  (pri_in_n_i),
    .cmd_i       (cmd_i),
    .cmd_stb_i   (cmd_stb_i),
    .irq_en_i    (irq_en_i),
    .vector_i    (vector_i),
    .irq_req_n_o (irq_req_n_o),
    .pri_out_n_o (pri_out_n_o),
    .vbus_o      (vbus_o),
    .vbus_oe_o   (vbus_oe_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  // Driver: strobes a code and queues the expected bus result.
  task automatic send_cmd(input logic [4:0] code, input bit stb, input string req);
    sb_item_t it;
    bit granted;
    granted = model_pend && !pri_in_n_i;
    it.due = cyc + 1;
    it.req = req;
    it.oe  = stb && granted && (code == 5'h0F || code == 5'h13);
    it.d   = !it.oe ? 8'h00 : (code == 5'h0F ? vector_i[7:0] : vector_i[15:8]);
    sbq.push_back(it);
    cmd_i     = code;
    cmd_stb_i = stb;
    if (it.oe && code == 5'h13) model_pend = 0;
    step(1);
    cmd_stb_i = 1'b0;
    cmd_i     = 5'h00;
  endtask

  // Monitor: compares results in the cycle they are due.
  always @(negedge clk) begin
    if (sbq.size() > 0 && sbq[0].due == cyc) begin
      sb_item_t it;
      it = sbq.pop_front();
      check({it.req, " oe"}, {15'd0, vbus_oe_o}, {15'd0, it.oe});
      check({it.req, " data"}, {8'd0, vbus_o}, {8'd0, it.d});
    end
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; ext_irq_i = 1; pri_in_n_i = 1; cmd_i = 0; cmd_stb_i = 0;
    irq_en_i = 0; vector_i = 16'hB73C;
    step(3);
    rst_n = 1;
    step(1);
    check("R2 reset req", {15'd0, irq_req_n_o}, 16'd1);
    check("R3 reset pri_out", {15'd0, pri_out_n_o}, 16'd1);
    check("R8 reset oe", {15'd0, vbus_oe_o}, 16'd0);

    // Pass-through with nothing pending
    pri_in_n_i = 0;
    #1;
    check("R3 pass grant", {15'd0, pri_out_n_o}, 16'd0);
    check("R2 no pending", {15'd0, irq_req_n_o}, 16'd1);

    // Disabled: falling edge ignored
    ext_irq_i = 0;
    step(5);
    check("R7 edge while disabled", {15'd0, irq_req_n_o}, 16'd1);

    // Rising edge with enable on does not request
    irq_en_i = 1;
    ext_irq_i = 1;
    step(5);
    check("R1 rising ignored", {15'd0, irq_req_n_o}, 16'd1);

    // Falling edge with exact latency
    ext_irq_i = 0;
    step(2);
    check("R1 not yet after two edges", {15'd0, irq_req_n_o}, 16'd1);
    step(1);
    model_pend = 1;
    check("R1 request after three edges", {15'd0, irq_req_n_o}, 16'd0);
    check("R3 blocked while requesting", {15'd0, pri_out_n_o}, 16'd1);
    ext_irq_i = 1;
    step(3);

    // Upstream withdraws grant
    pri_in_n_i = 1;
    #1;
    check("R2 no grant", {15'd0, irq_req_n_o}, 16'd1);
    check("R3 no grant pri_out", {15'd0, pri_out_n_o}, 16'd1);

    send_cmd(5'h0F, 1, "R8 low byte ungranted");
    step(1);
    pri_in_n_i = 0;
    #1;
    send_cmd(5'h0F, 0, "R8 code without strobe");
    step(1);
    send_cmd(5'h0F, 1, "R4 low byte");
    send_cmd(5'h13, 1, "R5 high byte");
    #1;
    check("R5 cleared after high byte", {15'd0, irq_req_n_o}, 16'd1);
    check("R5 priority passes on", {15'd0, pri_out_n_o}, 16'd0);
    step(1);
    check("R8 drive ends", {15'd0, vbus_oe_o}, 16'd0);

    // Freeze: strobe cycle has pri_out low
    send_cmd(5'h10, 1, "R6 inhibit cmd");
    pri_in_n_i = 1;
    step(2);
    check("R6 pri_out frozen", {15'd0, pri_out_n_o}, 16'd0);
    check("R6 req frozen", {15'd0, irq_req_n_o}, 16'd1);
    send_cmd(5'h00, 1, "R6 release cmd");
    #1;
    check("R6 released pri_out", {15'd0, pri_out_n_o}, 16'd1);

    // Second vector with a new value
    vector_i = 16'h5AE1;
    pri_in_n_i = 0;
    ext_irq_i = 0;
    step(3);
    model_pend = 1;
    ext_irq_i = 1;
    check("R1 second request", {15'd0, irq_req_n_o}, 16'd0);
    send_cmd(5'h13, 1, "R5 high byte second");
    send_cmd(5'h0F, 1, "R8 low byte after clear");
    step(2);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule